// File: doc/BRIEF.md
# Negative-Count DMA Channel Controller

This block is one DMA channel for a 16-bit machine. It moves one word at a time between memory and a single peripheral. Before a transfer, software uses programmed writes to load three registers. The parameter register pair is selected by a control bit. It holds the transfer direction with the start address, and the word count, written as a negative number. A separate options register holds the peripheral's select code and two pulse enables.

After a start strobe, the channel waits for the peripheral to request. It then moves one word, either from the peripheral into memory or from memory out to the peripheral. After each word it increments both the address and the count. When the count reaches zero, it raises a completion flag and can optionally send a clear-control pulse to the peripheral. It can also send a set-control pulse after every word.

An abort input stops the transfer and leaves the residue visible. On an input transfer, the peripheral may end the transfer early, and the residue is again left readable. Software can then compute how many words were actually moved.

Top module: `dma_chan`

## Requirements
- R1: With `prm_sel_i`=0, a parameter write loads bit 15 as the direction (0 input, 1 output) and bits 14:0 as the start address; `addr_o` shows {direction, address}. With `prm_sel_i`=1, the write loads the count from bits 13:0, and `len_o` always reads bits 15:14 as 0.
- R2: An options write stores bit 15 as the per-word set-control enable, bit 13 as the end clear-control enable, and bits 5:0 as the select code, which drives `dev_sel_o`.
- R3: In an input transfer, while the channel waits, a request consumes one device word (`dev_rd_o`) and writes it to memory at the current address in the same cycle.
- R4: In an output transfer, a request issues `mem_rd_o` at the current address. One cycle later, `dev_wr_o` presents the memory word.
- R5: Each moved word increments the 15-bit address, which wraps modulo 2^15, and increments the 14-bit count by one.
- R6: When the count reaches zero after a word, the transfer completes: `done_o` goes to 1 and `busy_o` to 0. A start with a zero count completes at once and moves no word.
- R7: When enabled, `dev_stc_o` pulses for one cycle in the cycle after each moved word. When disabled, it never pulses.
- R8: When enabled, `dev_clc_o` pulses once at completion, one cycle before `done_o` rises. It never pulses on abort.
- R9: `abort_i` while busy returns the channel to idle. It sets `abrt_o`, leaves `done_o` at 0, and keeps the count residue.
- R10: In an input transfer, `dev_end_i` while waiting completes the transfer like R6, and the residue stays readable in `len_o`.
- R11: While busy, register writes and start strobes are ignored.
- R12: An accepted start clears both `done_o` and `abrt_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wdata_i | input | 16 | Register write data |
| prm_we_i | input | 1 | Parameter register write strobe |
| prm_sel_i | input | 1 | Parameter target: 0 address, 1 count |
| opt_we_i | input | 1 | Options register write strobe |
| start_i | input | 1 | Start strobe |
| abort_i | input | 1 | Abort the running transfer |
| addr_o | output | 16 | Direction and current address |
| len_o | output | 16 | Count residue, bits 15:14 zero |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Completion flag |
| abrt_o | output | 1 | Abort flag |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_addr_o | output | 15 | Memory word address |
| mem_wdata_o | output | 16 | Memory write data |
| mem_rdata_i | input | 16 | Memory read data, valid one cycle after `mem_rd_o` |
| dev_req_i | input | 1 | Peripheral word request |
| dev_end_i | input | 1 | Peripheral ends an input transfer |
| dev_rdata_i | input | 16 | Peripheral input word |
| dev_rd_o | output | 1 | Peripheral word consumed |
| dev_wr_o | output | 1 | Peripheral output word valid |
| dev_wdata_o | output | 16 | Peripheral output word |
| dev_sel_o | output | 6 | Peripheral select code |
| dev_stc_o | output | 1 | Set-control pulse |
| dev_clc_o | output | 1 | Clear-control pulse |

## Verification
The assertions check the following on every cycle:
- each moved word advances the count by exactly one;
- state stays frozen while busy without a step;
- an output word always follows a memory read;
- every set-control pulse follows a moved word;
- every clear-control pulse is followed by the completion flag;
- an abort never coincides with completion.

Some behaviours only the bench scenarios can show:
- the data that actually lands in memory or reaches the peripheral;
- address wrap;
- the exact residue after an abort or an early end;
- zero-count starts;
- flags being cleared by a new start.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int DATA_W   = 16;
  localparam int ADDR_W   = 15;
  localparam int CNT_W    = 14;
  localparam int SEL_W    = 6;
  localparam int STC_BIT  = 15;
  localparam int CLC_BIT  = 13;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_FETCH,
    ST_STEP,
    ST_FINISH
  } seq_state_e;
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int DW      = 16,
  parameter int AW      = 15,
  parameter int LW      = 14,
  parameter int SCW     = 6,
  parameter int STC_POS = 15,
  parameter int CLC_POS = 13
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [DW-1:0]  wdata_i,
  input  logic           prm_we_i,
  input  logic           prm_sel_i,
  input  logic           opt_we_i,
  input  logic           busy_i,
  input  logic           step_i,
  output logic           dir_o,
  output logic [AW-1:0]  addr_o,
  output logic [LW-1:0]  len_o,
  output logic           len_zero_o,
  output logic           stc_en_o,
  output logic           clc_en_o,
  output logic [SCW-1:0] sel_o
);
  logic           dir_q;
  logic [AW-1:0]  addr_q;
  logic [LW-1:0]  len_q;
  logic           stc_q, clc_q;
  logic [SCW-1:0] sel_q;

  // address / count: software writes only while idle, hardware steps while busy
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= 1'b0;
      addr_q <= '0;
      len_q  <= '0;
    end else if (!busy_i && prm_we_i) begin
      if (!prm_sel_i) begin
        dir_q  <= wdata_i[DW-1];
        addr_q <= wdata_i[AW-1:0];
      end else begin
        len_q  <= wdata_i[LW-1:0];
      end
    end else if (step_i) begin
      addr_q <= addr_q + 1'b1;
      len_q  <= len_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stc_q <= 1'b0;
      clc_q <= 1'b0;
      sel_q <= '0;
    end else if (!busy_i && opt_we_i) begin
      stc_q <= wdata_i[STC_POS];
      clc_q <= wdata_i[CLC_POS];
      sel_q <= wdata_i[SCW-1:0];
    end
  end

  assign dir_o      = dir_q;
  assign addr_o     = addr_q;
  assign len_o      = len_q;
  assign len_zero_o = (len_q == '0);
  assign stc_en_o   = stc_q;
  assign clc_en_o   = clc_q;
  assign sel_o      = sel_q;

  // R5
  len_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> len_q == LW'($past(len_q) + 1'b1));

  // R11
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !step_i) |=> (addr_q == $past(addr_q) && len_q == $past(len_q)));
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_chan_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic abort_i,
  input  logic dev_req_i,
  input  logic dev_end_i,
  input  logic dir_i,
  input  logic len_zero_i,
  input  logic stc_en_i,
  input  logic clc_en_i,
  output logic busy_o,
  output logic step_o,
  output logic mem_rd_o,
  output logic mem_wr_o,
  output logic dev_rd_o,
  output logic dev_wr_o,
  output logic dev_stc_o,
  output logic dev_clc_o,
  output logic done_o,
  output logic abrt_o
);
  seq_state_e st_q, st_d;
  logic done_q, abrt_q;
  logic set_done, set_abrt, accept;

  always_comb begin
    st_d      = st_q;
    step_o    = 1'b0;
    mem_rd_o  = 1'b0;
    mem_wr_o  = 1'b0;
    dev_rd_o  = 1'b0;
    dev_wr_o  = 1'b0;
    dev_stc_o = 1'b0;
    dev_clc_o = 1'b0;
    set_done  = 1'b0;
    set_abrt  = 1'b0;
    accept    = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        accept = 1'b1;
        st_d   = len_zero_i ? ST_FINISH : ST_WAIT;
      end
      ST_WAIT: begin
        if (abort_i) begin
          set_abrt = 1'b1;
          st_d     = ST_IDLE;
        end else if (dev_end_i && !dir_i) begin
          st_d = ST_FINISH;
        end else if (dev_req_i) begin
          if (!dir_i) begin
            dev_rd_o = 1'b1;
            mem_wr_o = 1'b1;
            step_o   = 1'b1;
            st_d     = ST_STEP;
          end else begin
            mem_rd_o = 1'b1;
            st_d     = ST_FETCH;
          end
        end
      end
      ST_FETCH: begin
        dev_wr_o = 1'b1;
        step_o   = 1'b1;
        st_d     = ST_STEP;
      end
      ST_STEP: begin
        dev_stc_o = stc_en_i;
        if (abort_i) begin
          set_abrt = 1'b1;
          st_d     = ST_IDLE;
        end else begin
          st_d = len_zero_i ? ST_FINISH : ST_WAIT;
        end
      end
      ST_FINISH: begin
        dev_clc_o = clc_en_i;
        set_done  = 1'b1;
        st_d      = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
      abrt_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        done_q <= 1'b0;
        abrt_q <= 1'b0;
      end else begin
        if (set_done) done_q <= 1'b1;
        if (set_abrt) abrt_q <= 1'b1;
      end
    end
  end

  assign busy_o = (st_q != ST_IDLE);
  assign done_o = done_q;
  assign abrt_o = abrt_q;

  // R4
  out_after_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_wr_o |-> $past(mem_rd_o));

  // R7
  stc_after_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_stc_o |-> $past(step_o));

  // R8
  clc_then_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_clc_o |=> (done_o && !busy_o));

  // R9
  abort_not_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(abrt_o) |-> (!done_o && !busy_o));
endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import dma_chan_pkg::*;
#(
  parameter int DW  = DATA_W,
  parameter int AW  = ADDR_W,
  parameter int LW  = CNT_W,
  parameter int SCW = SEL_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [DW-1:0]  wdata_i,
  input  logic           prm_we_i,
  input  logic           prm_sel_i,
  input  logic           opt_we_i,
  input  logic           start_i,
  input  logic           abort_i,
  output logic [DW-1:0]  addr_o,
  output logic [DW-1:0]  len_o,
  output logic           busy_o,
  output logic           done_o,
  output logic           abrt_o,
  output logic           mem_rd_o,
  output logic           mem_wr_o,
  output logic [AW-1:0]  mem_addr_o,
  output logic [DW-1:0]  mem_wdata_o,
  input  logic [DW-1:0]  mem_rdata_i,
  input  logic           dev_req_i,
  input  logic           dev_end_i,
  input  logic [DW-1:0]  dev_rdata_i,
  output logic           dev_rd_o,
  output logic           dev_wr_o,
  output logic [DW-1:0]  dev_wdata_o,
  output logic [SCW-1:0] dev_sel_o,
  output logic           dev_stc_o,
  output logic           dev_clc_o
);
  localparam int PAD_W = DW - LW;

  logic          dir, len_zero, stc_en, clc_en, step, busy;
  logic [AW-1:0] addr;
  logic [LW-1:0] len;

  dma_chan_regs #(
    .DW(DW), .AW(AW), .LW(LW), .SCW(SCW),
    .STC_POS(STC_BIT), .CLC_POS(CLC_BIT)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wdata_i    (wdata_i),
    .prm_we_i   (prm_we_i),
    .prm_sel_i  (prm_sel_i),
    .opt_we_i   (opt_we_i),
    .busy_i     (busy),
    .step_i     (step),
    .dir_o      (dir),
    .addr_o     (addr),
    .len_o      (len),
    .len_zero_o (len_zero),
    .stc_en_o   (stc_en),
    .clc_en_o   (clc_en),
    .sel_o      (dev_sel_o)
  );

  dma_chan_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .abort_i    (abort_i),
    .dev_req_i  (dev_req_i),
    .dev_end_i  (dev_end_i),
    .dir_i      (dir),
    .len_zero_i (len_zero),
    .stc_en_i   (stc_en),
    .clc_en_i   (clc_en),
    .busy_o     (busy),
    .step_o     (step),
    .mem_rd_o   (mem_rd_o),
    .mem_wr_o   (mem_wr_o),
    .dev_rd_o   (dev_rd_o),
    .dev_wr_o   (dev_wr_o),
    .dev_stc_o  (dev_stc_o),
    .dev_clc_o  (dev_clc_o),
    .done_o     (done_o),
    .abrt_o     (abrt_o)
  );

  assign busy_o      = busy;
  assign addr_o      = {dir, addr};
  assign len_o       = {{PAD_W{1'b0}}, len};
  assign mem_addr_o  = addr;
  assign mem_wdata_o = dev_rdata_i;
  assign dev_wdata_o = mem_rdata_i;
endmodule

// File: tb/dma_chan_test.sv
module dma_chan_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [15:0] wdata = '0;
  logic prm_we = 0, prm_sel = 0, opt_we = 0, start = 0, abort = 0, dev_end = 0;
  logic [15:0] addr_o, len_o, mem_wdata, mem_rdata, dev_rdata, dev_wdata;
  logic [14:0] mem_addr;
  logic busy, done, abrt, mem_rd, mem_wr, dev_rd, dev_wr, dev_stc, dev_clc, dev_req;
  logic [5:0] dev_sel;

  int checks = 0, fails = 0;
  int in_cnt = 0, out_cnt = 0, stc_cnt = 0, clc_cnt = 0;
  int req_stop = 1000000;
  logic req_en = 0;
  logic [15:0] mem [256];
  logic [15:0] olog [64];

  assign dev_req   = req_en && (in_cnt < req_stop);
  assign dev_rdata = 16'hA000 + in_cnt[15:0];

  dma_chan uut (
    .clk_i(clk), .rst_ni(rst_n), .wdata_i(wdata), .prm_we_i(prm_we),
    .prm_sel_i(prm_sel), .opt_we_i(opt_we), .start_i(start), .abort_i(abort),
    .addr_o(addr_o), .len_o(len_o), .busy_o(busy), .done_o(done), .abrt_o(abrt),
    .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .dev_req_i(dev_req),
    .dev_end_i(dev_end), .dev_rdata_i(dev_rdata), .dev_rd_o(dev_rd),
    .dev_wr_o(dev_wr), .dev_wdata_o(dev_wdata), .dev_sel_o(dev_sel),
    .dev_stc_o(dev_stc), .dev_clc_o(dev_clc)
  );

  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
    if (dev_rd) in_cnt <= in_cnt + 1;
    if (dev_wr) begin
      olog[out_cnt[5:0]] <= dev_wdata;
      out_cnt <= out_cnt + 1;
    end
    if (dev_stc) stc_cnt <= stc_cnt + 1;
    if (dev_clc) clc_cnt <= clc_cnt + 1;
  end

  typedef struct packed {
    logic        dir;
    logic [14:0] a;
    logic [7:0]  n;
    logic        stc;
    logic        clc;
  } vec_t;

  localparam vec_t VEC [4] = '{
    '{1'b0, 15'h0010, 8'd3, 1'b1, 1'b1},
    '{1'b1, 15'h0040, 8'd4, 1'b0, 1'b1},
    '{1'b0, 15'h7FFF, 8'd2, 1'b0, 1'b0},
    '{1'b1, 15'h0080, 8'd1, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic is_opt, input logic sel, input logic [15:0] d);
    @(negedge clk);
    wdata = d; prm_sel = sel; prm_we = !is_opt; opt_we = is_opt;
    @(negedge clk);
    prm_we = 0; opt_we = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 300; i++) begin
      if (done || abrt) return;
      @(negedge clk);
    end
    fails++;
    $display("FAIL R6 transfer never ended actual=busy expected=done");
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h5000 + 16'(i);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    chk("R1 reset addr", addr_o, 16'h0);
    chk("R1 reset len", len_o, 16'h0);
    chk("R6 reset busy", busy, 1'b0);
    chk("R6 reset done", done, 1'b0);
    chk("R9 reset abort", abrt, 1'b0);
    chk("R2 reset sel", dev_sel, 6'h0);

    // table of transfers
    for (int k = 0; k < 4; k++) begin
      automatic vec_t v = VEC[k];
      automatic int ib, ob, sb, cb;
      wr(1'b1, 1'b0, {v.stc, 1'b0, v.clc, 7'd0, 6'(k + 5)});
      wr(1'b0, 1'b0, {v.dir, v.a});
      wr(1'b0, 1'b1, 16'(-int'(v.n)));
      ib = in_cnt; ob = out_cnt; sb = stc_cnt; cb = clc_cnt;
      req_stop = 1000000; req_en = 1;
      pulse_start();
      wait_end();
      req_en = 0;
      chk("R6 done", done, 1'b1);
      chk("R6 idle", busy, 1'b0);
      chk("R9 no abort", abrt, 1'b0);
      chk("R5 count zero", len_o, 16'h0);
      chk("R5 addr advance", addr_o, {v.dir, 15'(v.a + 15'(v.n))});
      chk("R7 stc pulses", stc_cnt - sb, v.stc ? int'(v.n) : 0);
      chk("R8 clc pulses", clc_cnt - cb, int'(v.clc));
      chk("R2 select code", dev_sel, 6'(k + 5));
      for (int i = 0; i < int'(v.n); i++) begin
        automatic logic [7:0] ma = 8'(v.a + 15'(i));
        if (!v.dir) chk("R3 input word", mem[ma], 16'hA000 + 16'(ib + i));
        else        chk("R4 output word", olog[6'(ob + i)], 16'h5000 + 16'(ma));
      end
    end

    // register readback
    wr(1'b0, 1'b1, 16'hFFFD);
    chk("R1 len bits 15:14 zero", len_o, 16'h3FFD);
    wr(1'b0, 1'b0, 16'h8123);
    chk("R1 addr with direction", addr_o, 16'h8123);

    // busy writes ignored, start clears flag, abort
    begin
      automatic int cb;
      wr(1'b1, 1'b0, 16'h2005);
      wr(1'b0, 1'b0, 16'h0030);
      wr(1'b0, 1'b1, 16'h3FFC);
      cb = clc_cnt;
      req_en = 0;
      pulse_start();
      chk("R12 start clears done", done, 1'b0);
      repeat (2) @(negedge clk);
      chk("R11 busy waiting", busy, 1'b1);
      wr(1'b0, 1'b0, 16'h0999);
      chk("R11 addr write ignored", addr_o, 16'h0030);
      wr(1'b0, 1'b1, 16'h0000);
      chk("R11 len write ignored", len_o, 16'h3FFC);
      pulse_start();
      chk("R11 start ignored", busy, 1'b1);
      @(negedge clk); abort = 1;
      @(negedge clk); abort = 0;
      chk("R9 abort flag", abrt, 1'b1);
      chk("R9 not done", done, 1'b0);
      chk("R9 idle", busy, 1'b0);
      chk("R9 residue kept", len_o, 16'h3FFC);
      chk("R8 no clc on abort", clc_cnt - cb, 0);
    end

    // early end of an input transfer
    begin
      automatic int ib, cb;
      wr(1'b1, 1'b0, 16'h2006);
      wr(1'b0, 1'b0, 16'h0020);
      wr(1'b0, 1'b1, 16'h3FFB);
      ib = in_cnt; cb = clc_cnt;
      req_stop = ib + 2; req_en = 1;
      pulse_start();
      chk("R12 start clears abort", abrt, 1'b0);
      repeat (10) @(negedge clk);
      chk("R10 still busy", busy, 1'b1);
      chk("R5 addr after two words", addr_o, 16'h0022);
      @(negedge clk); dev_end = 1;
      @(negedge clk); dev_end = 0;
      wait_end();
      req_en = 0;
      chk("R10 done on end", done, 1'b1);
      chk("R10 residue", len_o, 16'h3FFD);
      chk("R8 clc at end", clc_cnt - cb, 1);
      chk("R3 first word", mem[8'h20], 16'hA000 + 16'(ib));
      chk("R3 second word", mem[8'h21], 16'hA000 + 16'(ib + 1));
    end

    // zero count start
    begin
      automatic int ib, cb, sb;
      wr(1'b1, 1'b0, 16'hA007);
      wr(1'b0, 1'b1, 16'h0000);
      ib = in_cnt; cb = clc_cnt; sb = stc_cnt;
      req_en = 1; req_stop = 1000000;
      pulse_start();
      wait_end();
      req_en = 0;
      chk("R6 zero count done", done, 1'b1);
      chk("R6 zero count no word", in_cnt - ib, 0);
      chk("R7 zero count no stc", stc_cnt - sb, 0);
      chk("R8 zero count clc", clc_cnt - cb, 1);
    end

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule